// File: doc/BRIEF.md
# Byte and Half-Word Banked Memory

This block is a small 16-bit memory made of two 8-bit banks with a steering network between the banks and a 16-bit data bus. A caller can move a whole half-word in one access, or a single byte. The even byte of each row sits in one bank and the odd byte in the other. Both banks see the same row address, which is the byte address with its lowest bit removed.

The lowest address bit therefore matters only for byte transfers, where it picks the bank. A byte read is always returned right-justified on bus bits 7..0, and the upper lane reads as zero. A byte write always takes its value from bus bits 7..0, and only the addressed bank is enabled. A half-word request at an odd address is not split into two accesses. It touches the aligned pair below it, and a flag output reports the request.

Reads are combinational from the present address and controls. Writes are captured on the rising clock edge when the write strobe is high and the direction control selects a write.

Top module: `byte_half_mem`

## Requirements
- R1: Bank 0 holds the bytes at even addresses and maps to bus bits 7..0. Bank 1 holds the bytes at odd addresses and maps to bus bits 15..8.
- R2: A half-word access (size_byte = 0) ignores address bit 0. A half-word read at odd address 2k+1 returns the same value as a read at 2k.
- R3: Direction control dir_rd = 0 selects a write and dir_rd = 1 selects a read. With dir_rd = 1, a high wr_stb changes no stored byte.
- R4: A write happens only on a rising clock edge where wr_stb = 1 and dir_rd = 0. With wr_stb = 0, no stored byte changes.
- R5: In a byte read (size_byte = 1), address bit 0 = 0 returns the even byte on rdata[7:0] and address bit 0 = 1 returns the odd byte on rdata[7:0]. In both cases rdata[15:8] = 0.
- R6: A half-word write stores wdata[7:0] at the even byte of the row and wdata[15:8] at the odd byte. A half-word read returns {odd byte, even byte}.
- R7: A byte write stores wdata[7:0] into the bank chosen by address bit 0, whatever wdata[15:8] holds. The other bank's byte in that row is unchanged.
- R8: The output misaligned is 1 exactly when size_byte = 0 and address bit 0 = 1, independent of dir_rd and wr_stb.
- R9: rdata follows addr and size_byte in the same cycle with no clock edge. A written value is visible on rdata right after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge |
| addr | input | ADDR_W | Byte address |
| dir_rd | input | 1 | 0 = write from bus, 1 = read to bus |
| size_byte | input | 1 | 1 = byte transfer, 0 = half-word transfer |
| wr_stb | input | 1 | Write strobe |
| wdata | input | 16 | Write data bus |
| rdata | output | 16 | Read data bus |
| misaligned | output | 1 | Half-word request at an odd address |

## Verification
The bench fills every byte with a distinct value through byte writes, then reads every address both as a byte and as a half-word. A design that swapped the banks, or that fed address bit 0 into the row, would return bytes from the wrong places. The high-byte write carries a decoy in wdata[15:8], so a design that took the high lane would store the wrong value. Every byte read checks the zero upper lane. Strobes with dir_rd = 1, and writes with the strobe low, are each followed by a full read-back to catch stray writes. Odd half-word writes must land on the aligned pair below, and the flag is swept over every combination of size, address bit 0 and direction.

// File: rtl/bhm_pkg.sv
package bhm_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int BUS_W  = LANE_W * LANES;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_HALF,
        WK_LO,
        WK_HI
    } wr_kind_e;

    typedef enum logic [1:0] {
        RK_HALF,
        RK_LO,
        RK_HI
    } rd_kind_e;

endpackage

// File: rtl/bhm_decode.sv
module bhm_decode
    import bhm_pkg::*;
(
    input  logic           dir_rd,
    input  logic           size_byte,
    input  logic           a0,
    input  logic           wr_stb,
    output wr_kind_e       wr_kind,
    output rd_kind_e       rd_kind,
    output logic [LANES-1:0] bank_we,
    output logic           misaligned
);

    always_comb begin
        wr_kind = WK_NONE;
        if (wr_stb && !dir_rd) begin
            unique case ({size_byte, a0})
                2'b00, 2'b01: wr_kind = WK_HALF;
                2'b10:        wr_kind = WK_LO;
                2'b11:        wr_kind = WK_HI;
                default:      wr_kind = WK_NONE;
            endcase
        end
    end

    always_comb begin
        unique case ({size_byte, a0})
            2'b10:   rd_kind = RK_LO;
            2'b11:   rd_kind = RK_HI;
            default: rd_kind = RK_HALF;
        endcase
    end

    always_comb begin
        unique case (wr_kind)
            WK_HALF: bank_we = 2'b11;
            WK_LO:   bank_we = 2'b01;
            WK_HI:   bank_we = 2'b10;
            default: bank_we = 2'b00;
        endcase
    end

    assign misaligned = !size_byte && a0;

    always_comb begin
        if (dir_rd) begin
            p_no_write_on_read_r3: assert (bank_we == '0)
                else $error("write enable raised during a read");
        end
        if (!wr_stb) begin
            p_no_write_without_strobe_r4: assert (bank_we == '0)
                else $error("write enable raised without strobe");
        end
        if (wr_stb && !dir_rd && size_byte) begin
            p_byte_one_bank_r7: assert ($countones(bank_we) == 1)
                else $error("byte write must enable exactly one bank");
        end
    end

endmodule

// File: rtl/bhm_bank.sv
module bhm_bank #(
    parameter int ROW_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[row] <= din;
        end
    end

    assign dout = cells[row];

endmodule

// File: rtl/bhm_align.sv
module bhm_align
    import bhm_pkg::*;
(
    input  rd_kind_e                    rd_kind,
    input  wr_kind_e                    wr_kind,
    input  logic [BUS_W-1:0]            wdata,
    input  logic [LANES-1:0][LANE_W-1:0] bank_dout,
    output logic [LANES-1:0][LANE_W-1:0] bank_din,
    output logic [BUS_W-1:0]            rdata
);

    always_comb begin
        bank_din[0] = wdata[LANE_W-1:0];
        unique case (wr_kind)
            WK_HALF: bank_din[1] = wdata[BUS_W-1:LANE_W];
            default: bank_din[1] = wdata[LANE_W-1:0];
        endcase
    end

    always_comb begin
        unique case (rd_kind)
            RK_LO:   rdata = {{LANE_W{1'b0}}, bank_dout[0]};
            RK_HI:   rdata = {{LANE_W{1'b0}}, bank_dout[1]};
            default: rdata = {bank_dout[1], bank_dout[0]};
        endcase
    end

endmodule

// File: rtl/byte_half_mem.sv
module byte_half_mem
    import bhm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dir_rd,
    input  logic              size_byte,
    input  logic              wr_stb,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              misaligned
);

    localparam int ROW_W = ADDR_W - 1;

    wr_kind_e                     wr_kind;
    rd_kind_e                     rd_kind;
    logic [LANES-1:0]             bank_we;
    logic [LANES-1:0][LANE_W-1:0] bank_din;
    logic [LANES-1:0][LANE_W-1:0] bank_dout;
    logic [ROW_W-1:0]             row;

    assign row = addr[ADDR_W-1:1];

    bhm_decode u_decode (
        .dir_rd     (dir_rd),
        .size_byte  (size_byte),
        .a0         (addr[0]),
        .wr_stb     (wr_stb),
        .wr_kind    (wr_kind),
        .rd_kind    (rd_kind),
        .bank_we    (bank_we),
        .misaligned (misaligned)
    );

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        bhm_bank #(
            .ROW_W  (ROW_W),
            .DATA_W (LANE_W)
        ) u_bank (
            .clk  (clk),
            .we   (bank_we[b]),
            .row  (row),
            .din  (bank_din[b]),
            .dout (bank_dout[b])
        );
    end

    bhm_align u_align (
        .rd_kind   (rd_kind),
        .wr_kind   (wr_kind),
        .wdata     (wdata),
        .bank_dout (bank_dout),
        .bank_din  (bank_din),
        .rdata     (rdata)
    );

    always_comb begin
        if (size_byte) begin
            p_byte_upper_zero_r5: assert (rdata[15:8] == 8'h00)
                else $error("byte read left upper lane non-zero");
        end else begin
            p_half_pair_r6: assert (rdata == {bank_dout[1], bank_dout[0]})
                else $error("half read does not return bank pair");
        end
        if (misaligned) begin
            p_flag_half_only_r8: assert (!size_byte && addr[0])
                else $error("misaligned flag on an aligned or byte access");
        end
    end

endmodule

// File: tb/byte_half_mem_test.sv
`timescale 1ns/1ps
module byte_half_mem_test;

    localparam int AW = 8;
    localparam int NB = 1 << AW;

    logic          clk = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          dir_rd = 1'b1;
    logic          size_byte = 1'b1;
    logic          wr_stb = 1'b0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          misaligned;

    int total = 0;
    int bad = 0;
    logic [7:0] model [NB];

    always #2.5 clk = ~clk;

    byte_half_mem #(.ADDR_W(AW)) uut (
        .clk        (clk),
        .addr       (addr),
        .dir_rd     (dir_rd),
        .size_byte  (size_byte),
        .wr_stb     (wr_stb),
        .wdata      (wdata),
        .rdata      (rdata),
        .misaligned (misaligned)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, addr, act, exp);
        end
    endtask

    task automatic do_write(input int a, input bit byte_sz, input logic [15:0] d,
                            input bit rd, input bit stb);
        @(negedge clk);
        addr = a[AW-1:0]; size_byte = byte_sz; wdata = d; dir_rd = rd; wr_stb = stb;
        @(posedge clk);
        #1;
        wr_stb = 1'b0; dir_rd = 1'b1;
    endtask

    task automatic rd_byte(input int a, input string req);
        @(negedge clk);
        addr = a[AW-1:0]; size_byte = 1'b1; dir_rd = 1'b1; wr_stb = 1'b0;
        #1;
        check(req, rdata, {8'h00, model[a]});
    endtask

    task automatic rd_half(input int a, input string req);
        int e;
        e = a & ~1;
        @(negedge clk);
        addr = a[AW-1:0]; size_byte = 1'b0; dir_rd = 1'b1; wr_stb = 1'b0;
        #1;
        check(req, rdata, {model[e+1], model[e]});
    endtask

    task automatic sweep_bytes(input string req);
        for (int a = 0; a < NB; a++) rd_byte(a, req);
    endtask

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R8 idle state of the flag: byte size at address 0
        #1;
        check("R8 initial flag", {15'd0, misaligned}, 16'd0);

        // R1 R7 R9: byte writes of a distinct pattern, decoy in upper lane
        for (int a = 0; a < NB; a++) begin
            model[a] = 8'((a * 37 + 11) ^ (a >> 3));
            do_write(a, 1'b1, {~model[a], model[a]}, 1'b0, 1'b1);
        end
        sweep_bytes("R5 R7 byte readback");
        // R1 R2 half reads at every address
        for (int a = 0; a < NB; a++) rd_half(a, "R1 R2 half read");

        // R9: read is combinational, changes with address without an edge
        @(negedge clk);
        addr = 8'd5; size_byte = 1'b1; dir_rd = 1'b1;
        #0.5; check("R9 comb read a", rdata, {8'h00, model[5]});
        addr = 8'd6;
        #0.5; check("R9 comb read b", rdata, {8'h00, model[6]});

        // R6: half writes on even rows, odd rows use odd address (R2)
        for (int a = 0; a < NB; a += 2) begin
            logic [15:0] v;
            v = 16'((a * 613 + 4097) ^ 16'h5a3c);
            model[a] = v[7:0];
            model[a+1] = v[15:8];
            do_write(((a >> 1) % 2 == 1) ? a + 1 : a, 1'b0, v, 1'b0, 1'b1);
        end
        sweep_bytes("R6 half write bytes");
        for (int a = 0; a < NB; a += 2) rd_half(a, "R6 half write pair");

        // R7: one high-byte write, neighbour unchanged
        model[41] = 8'hc3;
        do_write(41, 1'b1, 16'hffc3, 1'b0, 1'b1);
        rd_byte(41, "R7 hi byte from low lane");
        rd_byte(40, "R7 neighbour kept");
        model[80] = 8'h7e;
        do_write(80, 1'b1, 16'h817e, 1'b0, 1'b1);
        rd_half(80, "R7 lo byte only");

        // R3: strobe during read direction changes nothing
        for (int a = 0; a < NB; a += 17) do_write(a, a % 2 == 0, 16'hdead, 1'b1, 1'b1);
        sweep_bytes("R3 no write while reading");

        // R4: write direction without strobe changes nothing
        for (int a = 0; a < NB; a += 13) do_write(a, a % 3 == 0, 16'hbeef, 1'b0, 1'b0);
        sweep_bytes("R4 no write without strobe");

        // R8: flag over size, bit0 and direction
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            size_byte = c[0]; addr = {7'd9, c[1]}; dir_rd = c[2]; wr_stb = 1'b0;
            #1;
            check("R8 misaligned flag", {15'd0, misaligned},
                  {15'd0, (c[0] == 0) && (c[1] == 1)});
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule